// File: doc/BRIEF.md
# Width-Matching FIFO Read Port with Byte Reordering

This block sits on the read side of a FIFO whose entries are 36 bits wide, organised as four 9-bit byte lanes, lane A being the most significant (bits 35:27) and lane D the least significant (bits 8:0). It hands each entry to a narrower consumer. A static size input selects the port width. In word width each entry leaves as two 18-bit pieces. In byte width it leaves as four 9-bit pieces on the low lanes of the read bus. A 2-bit reorder select picks one of four byte permutations.

The FIFO is read once per entry. The pop is issued on the read that takes the first piece, and the remaining pieces come from a held copy of the entry. A port-side "data available" flag stays high while held pieces remain or the FIFO reports data. It drops only when the last piece of the final entry has gone. The consumer pulses a read enable, and each accepted read loads the registered output bus on that clock edge.

Top module: `rdbm_top`

## Requirements
- R1: In word width (`size_byte`=0) an entry leaves as two 18-bit pieces. The piece order for each `swap_sel` value is: 00 gives AB then CD, 01 gives DC then BA, 10 gives CD then AB, and 11 gives BA then DC. The first-named byte of each piece sits in bits 17:9.
- R2: In byte width (`size_byte`=1) an entry leaves as four pieces on `rd_data[8:0]`. The byte order for each `swap_sel` value is: 00 gives A,B,C,D, 01 gives D,C,B,A, 10 gives C,D,A,B, and 11 gives B,A,D,C.
- R3: In byte width, `rd_data[17:9]` keeps the value it last held and is not cleared.
- R4: `fifo_pop` is high only in a cycle where `rd_en` is high, `fifo_empty` is low and no piece of an earlier entry is still held. The FIFO is popped exactly once per entry.
- R5: `port_avail` stays high while pieces of a fetched entry remain. With the FIFO empty, it goes low right after the edge that delivers the last piece (the second word, or the fourth byte).
- R6: With no piece held, `port_avail` follows `fifo_empty` inverted, with no added cycles. The caller synchronises `fifo_empty` to this clock.
- R7: `swap_sel` and `size_byte` are captured on the read that fetches an entry. A change to either input while later pieces of that entry are pending does not alter those pieces.
- R8: A read with `port_avail` low is ignored: `rd_data` keeps its value and no pop is issued.
- R9: After reset, `rd_data` is zero, no piece is held, and `port_avail` is low while the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| fifo_empty | input | 1 | FIFO has no entry (synchronous to clk) |
| fifo_data | input | 36 | Head entry of the FIFO, valid while not empty |
| fifo_pop | output | 1 | Removes the head entry at the next edge |
| size_byte | input | 1 | Port width: 0 word (18 bits), 1 byte (9 bits); static |
| swap_sel | input | 2 | Byte permutation select |
| rd_en | input | 1 | Read request for the next piece |
| rd_data | output | 18 | Registered read bus |
| port_avail | output | 1 | High when a piece can be read; low means empty |

## Verification
Entries whose four bytes all differ are read under every reorder value in both widths. A swapped lane or a wrong permutation therefore shows up as a wrong byte, not as an equal one. The byte-width runs follow a word-width read that left a known upper half, so clearing or overwriting bits 17:9 is visible. Reading several entries back to back with `rd_en` held high separates fetching from the FIFO from serving held pieces, and the bench counts the pops for this. A reorder change between pieces shows whether the mode is sampled at fetch time. Reads attempted on an empty port check that nothing moves.

// File: rtl/rdbm_pkg.sv
package rdbm_pkg;
  localparam int LANES = 4;
  localparam int IDX_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SWP_ABCD = 2'b00,
    SWP_DCBA = 2'b01,
    SWP_CDAB = 2'b10,
    SWP_BADC = 2'b11
  } swap_e;

  // Each permutation is the natural (A first) order with the position index
  // XOR-ed by a per-mode key; lane index 3 is byte A, lane 0 is byte D.
  function automatic logic [IDX_W-1:0] swap_key(swap_e m);
    case (m)
      SWP_ABCD: swap_key = 2'd0;
      SWP_DCBA: swap_key = 2'd3;
      SWP_CDAB: swap_key = 2'd2;
      default:  swap_key = 2'd1;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] lane_of(swap_e m, logic [IDX_W-1:0] pos);
    lane_of = 2'd3 ^ pos ^ swap_key(m);
  endfunction
endpackage

// File: rtl/rdbm_rst_sync.sv
module rdbm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/rdbm_ctrl.sv
module rdbm_ctrl
  import rdbm_pkg::*;
#(
  parameter int ENTRY_W = 36
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic               fifo_empty,
  input  logic [ENTRY_W-1:0] fifo_data,
  input  logic [1:0]         swap_sel,
  input  logic               size_byte,
  output logic               fifo_pop,
  output logic               port_avail,
  output logic               fire,
  output logic [ENTRY_W-1:0] sel_entry,
  output swap_e              sel_mode,
  output logic               sel_byte,
  output logic [IDX_W-1:0]   sel_idx
);
  localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(LANES - 1);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(LANES / 2 - 1);

  logic               held_q, held_d;
  logic [IDX_W-1:0]   cnt_q, cnt_d;
  logic [ENTRY_W-1:0] hold_q;
  swap_e              mode_q;
  logic               byte_q;
  logic               load;
  logic [IDX_W-1:0]   last_idx;

  always_comb begin
    port_avail = held_q | ~fifo_empty;
    fire       = rd_en & port_avail;
    load       = fire & ~held_q;
    fifo_pop   = load;

    sel_entry  = load ? fifo_data         : hold_q;
    sel_mode   = load ? swap_e'(swap_sel) : mode_q;
    sel_byte   = load ? size_byte         : byte_q;
    sel_idx    = load ? '0                : cnt_q;
    last_idx   = byte_q ? LAST_BYTE : LAST_WORD;

    held_d = held_q;
    cnt_d  = cnt_q;
    if (load) begin
      held_d = 1'b1;
      cnt_d  = IDX_W'(1);
    end else if (fire) begin
      if (cnt_q == last_idx) begin
        held_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      held_q <= held_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      mode_q <= SWP_ABCD;
      byte_q <= 1'b0;
    end else if (load) begin
      hold_q <= fifo_data;
      mode_q <= swap_e'(swap_sel);
      byte_q <= size_byte;
    end
  end
endmodule

// File: rtl/rdbm_swizzle.sv
module rdbm_swizzle
  import rdbm_pkg::*;
#(
  parameter int BYTE_W = 9,
  localparam int ENTRY_W = LANES * BYTE_W,
  localparam int PORT_W  = 2 * BYTE_W
) (
  input  logic [ENTRY_W-1:0] entry,
  input  swap_e              mode,
  input  logic               is_byte,
  input  logic [IDX_W-1:0]   idx,
  output logic [PORT_W-1:0]  piece
);
  // out lane 0 = low half of the port, out lane 1 = high half
  for (genvar g = 0; g < 2; g++) begin : g_out
    logic [IDX_W-1:0]  pos;
    logic [IDX_W-1:0]  lane;
    logic [BYTE_W-1:0] val;

    always_comb begin
      if (g == 0) pos = is_byte ? idx : {idx[0], 1'b1};
      else        pos = {idx[0], 1'b0};
      lane = lane_of(mode, pos);
      val  = '0;
      for (int i = 0; i < LANES; i++) begin
        if (lane == IDX_W'(i)) val = entry[i*BYTE_W +: BYTE_W];
      end
    end

    assign piece[g*BYTE_W +: BYTE_W] = val;
  end
endmodule

// File: rtl/rdbm_outreg.sv
module rdbm_outreg #(
  parameter int BYTE_W = 9,
  localparam int PORT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              is_byte,
  input  logic [PORT_W-1:0] piece,
  output logic [PORT_W-1:0] rd_data
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic              en;
    logic [BYTE_W-1:0] q;

    // the high lane only loads on word-width pieces
    assign en = fire & ((g == 0) | ~is_byte);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= piece[g*BYTE_W +: BYTE_W];
    end

    assign rd_data[g*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/rdbm_top.sv
module rdbm_top
  import rdbm_pkg::*;
#(
  parameter int BYTE_W     = 9,
  parameter int SYNC_STAGE = 2,
  localparam int ENTRY_W = LANES * BYTE_W,
  localparam int PORT_W  = 2 * BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_empty,
  input  logic [ENTRY_W-1:0] fifo_data,
  output logic               fifo_pop,
  input  logic               size_byte,
  input  logic [1:0]         swap_sel,
  input  logic               rd_en,
  output logic [PORT_W-1:0]  rd_data,
  output logic               port_avail
);
  logic               rst_sync_n;
  logic               fire;
  logic [ENTRY_W-1:0] sel_entry;
  swap_e              sel_mode;
  logic               sel_byte;
  logic [IDX_W-1:0]   sel_idx;
  logic [PORT_W-1:0]  piece;

  rdbm_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  rdbm_ctrl #(.ENTRY_W(ENTRY_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd_en      (rd_en),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .swap_sel   (swap_sel),
    .size_byte  (size_byte),
    .fifo_pop   (fifo_pop),
    .port_avail (port_avail),
    .fire       (fire),
    .sel_entry  (sel_entry),
    .sel_mode   (sel_mode),
    .sel_byte   (sel_byte),
    .sel_idx    (sel_idx)
  );

  rdbm_swizzle #(.BYTE_W(BYTE_W)) u_swz (
    .entry   (sel_entry),
    .mode    (sel_mode),
    .is_byte (sel_byte),
    .idx     (sel_idx),
    .piece   (piece)
  );

  rdbm_outreg #(.BYTE_W(BYTE_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fire    (fire),
    .is_byte (sel_byte),
    .piece   (piece),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/rdbm_chk.sv
module rdbm_chk #(
  parameter int PORT_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              fifo_empty,
  input logic              fifo_pop,
  input logic              port_avail,
  input logic              size_byte,
  input logic [PORT_W-1:0] rd_data
);
  localparam int HALF = PORT_W / 2;

  // R4
  pop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (rd_en && !fifo_empty));

  // R5
  pop_keeps_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> port_avail);

  // R8
  idle_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !port_avail) |=> $stable(rd_data));

  // R8
  idle_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_avail |-> !fifo_pop);

  // R3
  byte_upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_byte && $past(size_byte)) |-> $stable(rd_data[PORT_W-1:HALF]));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (rd_data == '0));
endmodule

bind rdbm_top rdbm_chk #(.PORT_W(PORT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .rd_en      (rd_en),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop),
  .port_avail (port_avail),
  .size_byte  (size_byte),
  .rd_data    (rd_data)
);

// File: tb/tb_rdbm_top.sv
module tb_rdbm_top;
  logic        clk;
  logic        rst_n;
  logic        fifo_empty;
  logic [35:0] fifo_data;
  logic        fifo_pop;
  logic        size_byte;
  logic [1:0]  swap_sel;
  logic        rd_en;
  logic [17:0] rd_data;
  logic        port_avail;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // bench FIFO model
  logic [35:0] mem [64];
  int wptr = 0;
  int rptr = 0;
  assign fifo_empty = (wptr == rptr);
  assign fifo_data  = mem[rptr[5:0]];

  always @(posedge clk) if (fifo_pop) rptr <= rptr + 1;

  // scoreboard
  logic [17:0] exp_q [$];
  string       tag_q [$];
  logic [8:0]  up_model = '0;

  rdbm_top dut (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .size_byte(size_byte), .swap_sel(swap_sel),
    .rd_en(rd_en), .rd_data(rd_data), .port_avail(port_avail)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // letter order per mode; 3=A 2=B 1=C 0=D
  function automatic int ord(input logic [1:0] m, input int k);
    int t0[4] = '{3, 2, 1, 0};
    int t1[4] = '{0, 1, 2, 3};
    int t2[4] = '{1, 0, 3, 2};
    int t3[4] = '{2, 3, 0, 1};
    case (m)
      2'b00:   return t0[k];
      2'b01:   return t1[k];
      2'b10:   return t2[k];
      default: return t3[k];
    endcase
  endfunction

  function automatic logic [8:0] bsel(input logic [35:0] e, input int lane);
    return e[lane*9 +: 9];
  endfunction

  // driver: store entry and queue the pieces expected for current settings
  task automatic push(input logic [35:0] e, input string tag);
    mem[wptr[5:0]] = e;
    wptr = wptr + 1;
    if (!size_byte) begin
      for (int j = 0; j < 2; j++) begin
        exp_q.push_back({bsel(e, ord(swap_sel, 2*j)), bsel(e, ord(swap_sel, 2*j+1))});
        tag_q.push_back(tag);
      end
      up_model = bsel(e, ord(swap_sel, 2));
    end else begin
      for (int j = 0; j < 4; j++) begin
        exp_q.push_back({up_model, bsel(e, ord(swap_sel, j))});
        tag_q.push_back(tag);
      end
    end
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_en = 1;
    end
    @(negedge clk);
    rd_en = 0;
  endtask

  // monitor
  initial begin
    forever begin
      bit f;
      @(posedge clk);
      f = rd_en && port_avail;
      #2;
      if (f) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4 unexpected read", {18'd0, rd_data}, 36'd0);
        end else begin
          logic [17:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rd_data == e, t, {18'd0, rd_data}, {18'd0, e});
        end
      end
    end
  end

  // watchdog
  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [17:0] keep;
    int r0;
    rst_n = 0; rd_en = 0; size_byte = 0; swap_sel = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk(rd_data == 18'd0, "R9 rd_data", {18'd0, rd_data}, 36'd0);
    chk(port_avail == 0, "R9 port_avail", {35'd0, port_avail}, 36'd0);
    chk(fifo_pop == 0, "R9 fifo_pop", {35'd0, fifo_pop}, 36'd0);

    // R8 read while empty
    read_n(3);
    chk(rd_data == 18'd0, "R8 rd_data kept", {18'd0, rd_data}, 36'd0);
    chk(rptr == 0, "R8 no pop", 36'(rptr), 36'd0);

    // R1 word width, all four modes
    for (int m = 0; m < 4; m++) begin
      swap_sel = 2'(m);
      @(negedge clk);
      push(36'h0_4A5_3C7_1E9 ^ 36'(m * 9'h111), "R1 word order");
      #1;
      chk(port_avail == 1, "R6 avail on data", {35'd0, port_avail}, 36'd1);
      read_n(1);
      chk(port_avail == 1, "R5 avail after first word", {35'd0, port_avail}, 36'd1);
      read_n(1);
      chk(port_avail == 0, "R5 low after last word", {35'd0, port_avail}, 36'd0);
    end
    chk(rptr == 4, "R4 one pop per word entry", 36'(rptr), 36'd4);

    // R2/R3 byte width, all four modes
    size_byte = 1;
    for (int m = 0; m < 4; m++) begin
      swap_sel = 2'(m);
      @(negedge clk);
      push({9'h1A1, 9'h0B2, 9'h1C3, 9'h0D4} ^ 36'(m * 3), "R2 byte order");
      read_n(3);
      chk(port_avail == 1, "R5 avail before last byte", {35'd0, port_avail}, 36'd1);
      keep = rd_data;
      read_n(1);
      chk(port_avail == 0, "R5 low after last byte", {35'd0, port_avail}, 36'd0);
      chk(rd_data[17:9] == up_model, "R3 upper kept", {27'd0, rd_data[17:9]}, {27'd0, up_model});
      chk(rd_data[17:9] == keep[17:9], "R3 upper unchanged", {27'd0, rd_data[17:9]}, {27'd0, keep[17:9]});
    end

    // R4 back-to-back entries with continuous read enable
    swap_sel = 2'b10;
    r0 = rptr;
    push(36'h1_2345_6789, "R4 stream");
    push(36'hA_BCDE_F012, "R4 stream");
    push(36'h5_5AA5_3CC3, "R4 stream");
    read_n(4);
    chk(rptr == r0 + 1, "R4 one pop per four bytes", 36'(rptr), 36'(r0 + 1));
    read_n(8);
    chk(rptr == r0 + 3, "R4 pops for three entries", 36'(rptr), 36'(r0 + 3));
    chk(port_avail == 0, "R5 low after stream", {35'd0, port_avail}, 36'd0);

    // R7 reorder select changed mid-entry
    size_byte = 0;
    swap_sel = 2'b01;
    @(negedge clk);
    push(36'h9_8765_4321, "R7 mode held");
    read_n(1);
    swap_sel = 2'b10;
    read_n(1);
    @(negedge clk);
    push(36'h1_0F0F_0F0F, "R7 new mode");
    read_n(2);

    // R8 again after data, output retained
    keep = rd_data;
    read_n(2);
    chk(rd_data == keep, "R8 retained after empty", {18'd0, rd_data}, {18'd0, keep});

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all pieces delivered", 36'(exp_q.size()), 36'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule